// File: doc/BRIEF.md
# Cascadable Four-Channel Timer Bank

This block holds a bank of independent up-counting timers, four by default and 16 bits wide. Each channel has a reload value, an enable, a two-bit clock-divider select, a chaining mode and an interrupt enable. In divided mode a channel advances once every 1, 64, 256 or 1024 clocks. In chained mode a channel advances once for each overflow of the channel just below it, in the same clock as that overflow, so that two or more channels form one wider counter. When a channel steps past all-ones it takes its reload value rather than zero, and it may pulse its own interrupt request line.

Software uses a small synchronous register interface with a write strobe and a combinational read port. The address carries the channel number in its upper bits and a register select in bit 0. Interrupt requests leave the block on a vector in which channel n drives line IRQ_BASE + n. With the default IRQ_BASE of 3, channels 0 to 3 drive lines 3 to 6.

Top module: `cascade_timer_bank`

## Requirements
- R1: After reset every count reads 0, every control register reads 0 and every interrupt line is low.
- R2: Address = {channel, sel}. Writing sel=0 stores the reload value, and reading sel=0 returns the live count. sel=1 is control: bits [1:0] divider select, bit 2 chaining, bit 6 interrupt enable, bit 7 enable. A control read returns these bits and zero elsewhere.
- R3: An enable written while the channel is off loads the count from the reload value. The next clock only arms the channel and restarts its divider phase. The count then reads reload+m after 1 + m·D clocks from the enabling write, where D is the divide ratio.
- R4: Divider select codes 0, 1, 2 and 3 give divide ratios of 1, 64, 256 and 1024.
- R5: A step taken at all-ones loads the reload value, not zero.
- R6: With bit 6 set, the overflow of channel n raises irq_req[IRQ_BASE+n] for exactly the one cycle in which the count first shows the reload value. With bit 6 clear the line stays low. Lines below IRQ_BASE are always low.
- R7: A channel n > 0 with chaining set advances once per overflow of channel n-1, in the same clock, and ignores its divider.
- R8: The chaining bit has no effect on channel 0, which always counts divided clocks.
- R9: Writing control with enable clear freezes the count. Enabling again reloads it from the reload value.
- R10: A control write that keeps enable set does not reload the count or interrupt counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W (3) | Write address {channel, sel} |
| wr_data | input | CNT_W (16) | Write data |
| rd_addr | input | ADDR_W (3) | Read address {channel, sel} |
| rd_data | output | CNT_W (16) | Read data, combinational |
| irq_req | output | IRQ_BASE+NUM_CH (7) | Interrupt request pulses, channel n on line IRQ_BASE+n |

## Verification
The vector table starts a single channel from a chosen reload value under each of the four divider codes. Each wait is chosen so that the count lands exactly on, or one clock past, a divider boundary. These off-by-one pairs separate a correct arming cycle from an early or late first increment, and a wrong divide ratio from a right one. Reload values just below all-ones force a wrap, which tells a reload-on-overflow from a plain wrap to zero. Directed runs then compare chained against free-running counting, interrupt lines with the enable bit set and clear, and freeze, resume and rewrite of control while counting.

// File: rtl/ctb_pkg.sv
package ctb_pkg;
   localparam int MAX_SHIFT = 10;
   localparam int PRE_W     = MAX_SHIFT;

   typedef struct packed {
      logic       enable;
      logic       irq_en;
      logic       cascade;
      logic [1:0] psel;
   } ctb_ctl_t;

   function automatic logic [PRE_W-1:0] psel_mask(input logic [1:0] sel);
      int sh;
      case (sel)
         2'd0:    sh = 0;
         2'd1:    sh = 6;
         2'd2:    sh = 8;
         default: sh = MAX_SHIFT;
      endcase
      return PRE_W'((1 << sh) - 1);
   endfunction

   function automatic ctb_ctl_t ctl_from_bits(input logic [7:0] d);
      ctb_ctl_t c;
      c.enable  = d[7];
      c.irq_en  = d[6];
      c.cascade = d[2];
      c.psel    = d[1:0];
      return c;
   endfunction

   function automatic logic [7:0] ctl_to_bits(input ctb_ctl_t c);
      return {c.enable, c.irq_en, 3'b000, c.cascade, c.psel};
   endfunction
endpackage

// File: rtl/ctb_prescaler.sv
module ctb_prescaler #(
   parameter int PRE_W = ctb_pkg::PRE_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic [PRE_W-1:0] mask,
   output logic             tick
);
   logic [PRE_W-1:0] phase_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   phase_q <= '0;
      else if (clr) phase_q <= '0;
      else          phase_q <= phase_q + 1'b1;
   end

   assign tick = ((phase_q & mask) == mask);
endmodule

// File: rtl/ctb_channel.sv
module ctb_channel #(
   parameter int CNT_W     = 16,
   parameter bit CAN_CHAIN = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                ctl_wr,
   input  logic                rld_wr,
   input  logic [CNT_W-1:0]    wr_data,
   input  logic                chain_in,
   output logic [CNT_W-1:0]    count,
   output logic [CNT_W-1:0]    reload,
   output ctb_pkg::ctb_ctl_t   ctl,
   output logic                armed,
   output logic                ovf,
   output logic                irq
);
   import ctb_pkg::*;

   ctb_ctl_t new_ctl;
   logic     tick, src, stop, start, step;

   assign new_ctl = ctl_from_bits(wr_data[7:0]);
   assign stop    = ctl_wr & ~new_ctl.enable;
   assign start   = ctl_wr & new_ctl.enable & ~ctl.enable;

   ctb_prescaler #(.PRE_W(PRE_W)) u_pre (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (~armed),
      .mask  (psel_mask(ctl.psel)),
      .tick  (tick)
   );

   generate
      if (CAN_CHAIN) begin : g_chain
         assign src = ctl.cascade ? chain_in : tick;
      end else begin : g_free
         assign src = tick;
      end
   endgenerate

   assign step = armed & src & ~stop & ~start;
   assign ovf  = step & (&count);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count  <= '0;
         reload <= '0;
         ctl    <= '0;
         armed  <= 1'b0;
         irq    <= 1'b0;
      end else begin
         irq <= ovf & ctl.irq_en;
         if (rld_wr) reload <= wr_data;
         if (ctl_wr) ctl <= new_ctl;
         if (start) begin
            count <= reload;
            armed <= 1'b0;
         end else if (stop || !ctl.enable) begin
            armed <= 1'b0;
         end else if (!armed) begin
            armed <= 1'b1;
         end else if (step) begin
            count <= ovf ? reload : count + 1'b1;
         end
      end
   end
endmodule

// File: rtl/cascade_timer_bank.sv
module cascade_timer_bank #(
   parameter int NUM_CH   = 4,
   parameter int CNT_W    = 16,
   parameter int IRQ_BASE = 3,
   localparam int CH_W    = $clog2(NUM_CH),
   localparam int ADDR_W  = CH_W + 1,
   localparam int IRQ_W   = IRQ_BASE + NUM_CH
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [CNT_W-1:0]  wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [CNT_W-1:0]  rd_data,
   output logic [IRQ_W-1:0]  irq_req
);
   import ctb_pkg::*;

   if (NUM_CH < 2) begin : g_bad_ch
      $error("cascade_timer_bank: NUM_CH must be at least 2");
   end
   if (CNT_W < 8) begin : g_bad_w
      $error("cascade_timer_bank: CNT_W must hold the 8-bit control layout");
   end
   if (IRQ_BASE < 0) begin : g_bad_irq
      $error("cascade_timer_bank: IRQ_BASE must not be negative");
   end

   logic [NUM_CH-1:0][CNT_W-1:0] cnt_q;
   logic [NUM_CH-1:0][CNT_W-1:0] reload_q;
   ctb_ctl_t [NUM_CH-1:0]        ctl_q;
   logic [NUM_CH-1:0]            armed_q;
   logic [NUM_CH-1:0]            ovf_q;
   logic [NUM_CH-1:0]            irq_q;

   logic [CH_W-1:0] wr_ch, rd_ch;
   assign wr_ch = wr_addr[ADDR_W-1:1];
   assign rd_ch = rd_addr[ADDR_W-1:1];

   for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
      logic sel_hit, chain;
      assign sel_hit = wr_en && (wr_ch == CH_W'(n));
      if (n == 0) begin : g_first
         assign chain = 1'b0;
      end else begin : g_next
         assign chain = ovf_q[n-1];
      end
      ctb_channel #(.CNT_W(CNT_W), .CAN_CHAIN(n > 0)) u_ch (
         .clk      (clk),
         .rst_n    (rst_n),
         .ctl_wr   (sel_hit & wr_addr[0]),
         .rld_wr   (sel_hit & ~wr_addr[0]),
         .wr_data  (wr_data),
         .chain_in (chain),
         .count    (cnt_q[n]),
         .reload   (reload_q[n]),
         .ctl      (ctl_q[n]),
         .armed    (armed_q[n]),
         .ovf      (ovf_q[n]),
         .irq      (irq_q[n])
      );
   end

   always_comb begin
      rd_data = '0;
      for (int n = 0; n < NUM_CH; n++) begin
         if (rd_ch == CH_W'(n)) begin
            rd_data = rd_addr[0] ? CNT_W'(ctl_to_bits(ctl_q[n])) : cnt_q[n];
         end
      end
   end

   if (IRQ_BASE > 0) begin : g_irq_off
      assign irq_req = {irq_q, {IRQ_BASE{1'b0}}};
   end else begin : g_irq_flat
      assign irq_req = irq_q;
   end
endmodule

// File: rtl/ctb_checker.sv
module ctb_checker #(
   parameter int NUM_CH   = 4,
   parameter int CNT_W    = 16,
   parameter int IRQ_BASE = 3
) (
   input logic                         clk,
   input logic                         rst_n,
   input logic                         wr_en,
   input logic [IRQ_BASE+NUM_CH-1:0]   irq_req,
   input logic [NUM_CH-1:0][CNT_W-1:0] cnt_q,
   input logic [NUM_CH-1:0][CNT_W-1:0] reload_q,
   input ctb_pkg::ctb_ctl_t [NUM_CH-1:0] ctl_q,
   input logic [NUM_CH-1:0]            armed_q,
   input logic [NUM_CH-1:0]            ovf_q
);
   for (genvar n = 0; n < NUM_CH; n++) begin : g_chk
      assert_irq_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
         irq_req[IRQ_BASE+n] |-> $past(ovf_q[n] && ctl_q[n].irq_en));

      assert_irq_masked_R6: assert property (@(posedge clk) disable iff (!rst_n)
         (ovf_q[n] && !ctl_q[n].irq_en) |=> !irq_req[IRQ_BASE+n]);

      assert_reload_on_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
         ovf_q[n] |=> (cnt_q[n] == $past(reload_q[n])));

      assert_arm_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(ctl_q[n].enable) |=> $stable(cnt_q[n]));

      assert_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
         (!ctl_q[n].enable && !wr_en) |=> $stable(cnt_q[n]));

      if (n > 0) begin : g_chain
         assert_chain_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (armed_q[n] && ctl_q[n].cascade && !ovf_q[n-1] && !wr_en)
               |=> $stable(cnt_q[n]));
      end
   end
endmodule

bind cascade_timer_bank ctb_checker #(
   .NUM_CH(NUM_CH), .CNT_W(CNT_W), .IRQ_BASE(IRQ_BASE)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .wr_en    (wr_en),
   .irq_req  (irq_req),
   .cnt_q    (cnt_q),
   .reload_q (reload_q),
   .ctl_q    (ctl_q),
   .armed_q  (armed_q),
   .ovf_q    (ovf_q)
);

// File: tb/cascade_timer_bank_bench.sv
module cascade_timer_bank_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_addr = '0;
   logic [15:0] wr_data = '0;
   logic [2:0]  rd_addr = '0;
   logic [15:0] rd_data;
   logic [6:0]  irq_req;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #4 clk = ~clk;

   cascade_timer_bank u_cascade_timer_bank (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq_req(irq_req)
   );

   // {channel(2), divider select(2), reload(16), wait clocks(12), expected count(16)}
   localparam logic [47:0] VEC [8] = '{
      {2'd0, 2'd0, 16'h1000, 12'd5,    16'h1004},  // R3 R4 divide 1
      {2'd2, 2'd1, 16'h0100, 12'd129,  16'h0102},  // R4 divide 64
      {2'd0, 2'd2, 16'hFFFE, 12'd513,  16'hFFFE},  // R4 R5 divide 256 with wrap
      {2'd3, 2'd3, 16'h0010, 12'd1024, 16'h0010},  // R4 divide 1024, one clock short
      {2'd3, 2'd3, 16'h0010, 12'd1025, 16'h0011},  // R4 divide 1024, on boundary
      {2'd2, 2'd0, 16'hFFFD, 12'd4,    16'hFFFD},  // R5 wrap to reload
      {2'd1, 2'd0, 16'h0000, 12'd1,    16'h0000},  // R3 arming clock holds
      {2'd1, 2'd1, 16'h0007, 12'd64,   16'h0007}   // R3 R4 first step not yet due
   };

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input int ch, input int sel, input logic [15:0] d);
      wr_en   = 1'b1;
      wr_addr = {2'(ch), 1'(sel)};
      wr_data = d;
      @(posedge clk);
      @(negedge clk);
      wr_en   = 1'b0;
   endtask

   task automatic rd(input int ch, input int sel, output logic [15:0] v);
      rd_addr = {2'(ch), 1'(sel)};
      #1;
      v = rd_data;
   endtask

   task automatic wait_clk(input int j);
      repeat (j) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic all_off();
      for (int c = 0; c < 4; c++) wr(c, 1, 16'h0000);
   endtask

   initial begin
      repeat (2000000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [15:0] v;
      repeat (3) @(negedge clk);
      // R1 reset state
      for (int c = 0; c < 4; c++) begin
         rd(c, 0, v); check("R1 count", v, 16'h0000);
         rd(c, 1, v); check("R1 control", v, 16'h0000);
      end
      check("R1 irq", {9'd0, irq_req}, 16'h0000);
      rst_n = 1'b1;
      @(negedge clk);

      // R2 control readback keeps only defined bits
      wr(1, 1, 16'hFFFF);
      rd(1, 1, v); check("R2 control readback", v, 16'h00C7);
      all_off();

      // vector table: R2 live count read, R3, R4, R5
      for (int i = 0; i < 8; i++) begin
         int ch, ps, j;
         logic [15:0] rl, ex;
         ch = int'(VEC[i][47:46]);
         ps = int'(VEC[i][45:44]);
         rl = VEC[i][43:28];
         j  = int'(VEC[i][27:16]);
         ex = VEC[i][15:0];
         wr(ch, 1, 16'h0000);
         wr(ch, 0, rl);
         wr(ch, 1, 16'h0080 | 16'(ps));
         wait_clk(j);
         rd(ch, 0, v); check("R2 R3 R4 R5 vector", v, ex);
         wr(ch, 1, 16'h0000);
      end

      // R6 interrupt pulse on channel 1 -> line 4
      all_off();
      wr(1, 0, 16'hFFFE);
      wr(1, 1, 16'h00C0);
      wait_clk(3);
      check("R6 irq raised", {9'd0, irq_req}, 16'h0010);
      rd(1, 0, v); check("R5 R6 count at irq", v, 16'hFFFE);
      wait_clk(1);
      check("R6 irq one cycle", {9'd0, irq_req}, 16'h0000);
      wr(1, 1, 16'h0000);
      wr(1, 1, 16'h0080);
      wait_clk(3);
      check("R6 irq masked", {9'd0, irq_req}, 16'h0000);
      rd(1, 0, v); check("R6 masked still wraps", v, 16'hFFFE);

      // R7 chaining channel 1 onto channel 0
      all_off();
      wr(1, 0, 16'h0020);
      wr(1, 1, 16'h0084);
      wr(0, 0, 16'hFFFE);
      wr(0, 1, 16'h0080);
      wait_clk(6);
      rd(1, 0, v); check("R7 chained count", v, 16'h0022);
      rd(0, 0, v); check("R7 lower count", v, 16'hFFFF);

      // R8 chaining bit ignored on channel 0
      all_off();
      wr(0, 0, 16'h0005);
      wr(0, 1, 16'h0084);
      wait_clk(3);
      rd(0, 0, v); check("R8 channel 0 counts", v, 16'h0007);

      // R9 freeze and re-enable
      all_off();
      wr(3, 0, 16'h0040);
      wr(3, 1, 16'h0080);
      wait_clk(4);
      wr(3, 1, 16'h0000);
      rd(3, 0, v); check("R9 frozen", v, 16'h0043);
      wait_clk(10);
      rd(3, 0, v); check("R9 still frozen", v, 16'h0043);
      wr(3, 1, 16'h0080);
      rd(3, 0, v); check("R9 reload on enable", v, 16'h0040);

      // R10 rewrite of control while enabled
      wr(3, 1, 16'h0000);
      wr(3, 1, 16'h0080);
      wait_clk(4);
      wr(3, 1, 16'h0080);
      rd(3, 0, v); check("R10 no reload", v, 16'h0044);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule